// File: doc/BRIEF.md
# Debug Probe Control and Sense Register

This block is the control and status register of a debug probe. Software owns it through a small register bus. It drives the target reset lines, the target power switch, two indicator LEDs and the adaptive-clock selector. It also watches three sense inputs from the target side and holds each one in a sticky flag.

Control bits are never changed by read-modify-write. One address sets every control bit that is one in the written data. A second address clears those bits instead. Both addresses read back the same word. That word holds the control bits and the three sticky flags.

Each sense input passes through a configurable synchronizer before it reaches its flag. The reset-sense flag and the power-dropout flag are re-armed through the set address. Writing a one to the flag's bit reloads the flag with the current synchronized input, so a later read shows whether the condition is still present. The clock-timeout flag is cleared through the clear address. For all three flags, an event in the same cycle as a reload or clear wins, so no event is lost.

Top module: `dbg_ctl_status_reg`

## Requirements
- R1: A write to offset 0x10 sets every control bit whose data bit is one and leaves the other control bits unchanged. The change is visible from the next clock edge.
- R2: A write to offset 0x14 clears every control bit whose data bit is one and leaves the other control bits unchanged. The change is visible from the next clock edge.
- R3: Control bit 0 drives `srst_assert` and bit 1 drives `trst_assert`. A bit value of one asserts the output (output high).
- R4: Control bit 3 is the power-off bit. `pwr_en` is high exactly when bit 3 is zero.
- R5: Control bit 4 drives `led[0]`, control bit 5 drives `led[1]`, and control bit 8 drives `rclk_sel`.
- R6: A read at offset 0x10 and a read at offset 0x14 both return the same word, combinationally in the same cycle. Any other offset reads as zero. Bits 2, 9 and 11 and above always read zero.
- R7: Bit 6 (reset sensed) and bit 7 (power dropout) are sticky flags. Each sets SYNC_STAGES+1 clock edges after its input goes high, and stays set after the input falls.
- R8: A set-port write with bit 6 or bit 7 at one reloads that flag with its current synchronized input. A clear-port write has no effect on bits 6 and 7.
- R9: Bit 10 is a sticky clock-timeout flag with the same input latency as R7. A clear-port write with bit 10 at one clears it. A set-port write has no effect on it.
- R10: When a flag's synchronized input is high in the same cycle as a reload or clear of that flag, the flag stays set.
- R11: After reset, all control bits and all flags are zero. The resets are deasserted, `pwr_en` is high, the LEDs are off and `rclk_sel` is low.
- R12: Writes to unmapped offsets change nothing. Writes to undefined bits at the mapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current offset |
| srst_sense_in | input | 1 | Target reset observed, asynchronous |
| pwr_drop_in | input | 1 | Target power dropout observed, asynchronous |
| clk_timeout_in | input | 1 | Adaptive clock timeout observed, asynchronous |
| srst_assert | output | 1 | Drive target system reset |
| trst_assert | output | 1 | Drive target test reset |
| pwr_en | output | 1 | Target power switch on |
| led | output | 2 | Indicator LEDs |
| rclk_sel | output | 1 | Select adaptive (returned) clocking |

## Verification
Control outputs and the register word change on the first clock edge after a write. A read is combinational, so it reflects the current offset in the same cycle. A sense input reaches its flag after SYNC_STAGES+1 edges. The bench models this with a queue of SYNC_STAGES entries ahead of each flag.

Inputs are driven at the falling edge. The model advances on the rising edge. Every output is compared against the model at the next falling edge, so each check falls exactly one edge after the stimulus it depends on.

The directed latency checks look at the edge just before a flag is due as well as the edge on which it is due.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   // Bit positions that software decodes in the register word
   localparam int unsigned BIT_SRST      = 0;
   localparam int unsigned BIT_TRST      = 1;
   localparam int unsigned BIT_PWR_OFF   = 3;
   localparam int unsigned BIT_LED0      = 4;
   localparam int unsigned BIT_LED1      = 5;
   localparam int unsigned BIT_SRST_SEEN = 6;
   localparam int unsigned BIT_PWR_DROP  = 7;
   localparam int unsigned BIT_RCLK      = 8;
   localparam int unsigned BIT_CLK_TMO   = 10;

   localparam int unsigned WORD_MIN_W = BIT_CLK_TMO + 1;
   localparam int unsigned NUM_STICKY = 3;

   // How a sticky flag is reloaded by software
   typedef enum logic {
      REARM_BY_SET = 1'b0,
      CLEAR_BY_CLR = 1'b1
   } sticky_mode_e;

   // Index 0: reset sensed, 1: power dropout, 2: clock timeout
   function automatic int unsigned sticky_bit(input int unsigned idx);
      case (idx)
         0:       return BIT_SRST_SEEN;
         1:       return BIT_PWR_DROP;
         default: return BIT_CLK_TMO;
      endcase
   endfunction

   function automatic sticky_mode_e sticky_mode(input int unsigned idx);
      return (idx == 2) ? CLEAR_BY_CLR : REARM_BY_SET;
   endfunction

endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH == 0) begin : g_bad_width
      $error("dcs_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      // Inputs already synchronous to clk
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/dcs_sticky.sv
module dcs_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic reload_i,
   output logic flag_o
);

   logic flag_q;

   // A reload loads the live event, so a coincident event is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (reload_i) flag_q <= event_i;
      else               flag_q <= flag_q | event_i;
   end

   assign flag_o = flag_q;

   // R7 R10
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      event_i |=> flag_o);

   // R8 R9
   sticky_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_i && !event_i) |=> !flag_o);

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_i && !event_i) |=> $stable(flag_o));

endmodule

// File: rtl/dcs_ctl_reg.sv
module dcs_ctl_reg
   import dcs_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_wr,
   input  logic              clr_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctl_o
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
   localparam logic [DATA_W-1:0] CTL_MASK =
      (ONE << BIT_SRST) | (ONE << BIT_TRST) | (ONE << BIT_PWR_OFF) |
      (ONE << BIT_LED0) | (ONE << BIT_LED1) | (ONE << BIT_RCLK);

   logic [DATA_W-1:0] ctl_q;
   logic [DATA_W-1:0] sel;

   assign sel = wdata & CTL_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (set_wr) ctl_q <= ctl_q | sel;
      else if (clr_wr) ctl_q <= ctl_q & ~sel;
   end

   assign ctl_o = ctl_q;

   // R1
   set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> ((ctl_o & $past(wdata & CTL_MASK)) == $past(wdata & CTL_MASK)));

   // R2
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !set_wr) |=> ((ctl_o & $past(wdata)) == '0));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_wr && !clr_wr) |=> $stable(ctl_o));

endmodule

// File: rtl/dbg_ctl_status_reg.sv
module dbg_ctl_status_reg
   import dcs_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 8,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] SET_OFFSET  = 'h10,
   parameter logic [ADDR_W-1:0] CLR_OFFSET  = 'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              srst_sense_in,
   input  logic              pwr_drop_in,
   input  logic              clk_timeout_in,
   output logic              srst_assert,
   output logic              trst_assert,
   output logic              pwr_en,
   output logic [1:0]        led,
   output logic              rclk_sel
);

   if (SET_OFFSET == CLR_OFFSET) begin : g_bad_map
      $error("dbg_ctl_status_reg: set and clear offsets must differ");
   end
   if (DATA_W < WORD_MIN_W) begin : g_bad_data_w
      $error("dbg_ctl_status_reg: DATA_W too narrow for the register word");
   end

   logic                  hit_set, hit_clr;
   logic                  set_wr, clr_wr;
   logic [DATA_W-1:0]     ctl_word;
   logic [DATA_W-1:0]     word;
   logic [NUM_STICKY-1:0] sense_raw, sense_sync, sticky_q;

   assign hit_set = (bus_addr == SET_OFFSET);
   assign hit_clr = (bus_addr == CLR_OFFSET);
   assign set_wr  = bus_we & hit_set;
   assign clr_wr  = bus_we & hit_clr;

   dcs_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_wr (set_wr),
      .clr_wr (clr_wr),
      .wdata  (bus_wdata),
      .ctl_o  (ctl_word)
   );

   assign sense_raw = {clk_timeout_in, pwr_drop_in, srst_sense_in};

   dcs_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_STICKY)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sense_raw),
      .q     (sense_sync)
   );

   for (genvar i = 0; i < int'(NUM_STICKY); i++) begin : g_sticky
      localparam int unsigned FB = sticky_bit(i);
      logic reload;

      if (sticky_mode(i) == REARM_BY_SET) begin : g_rearm
         assign reload = set_wr & bus_wdata[FB];
      end else begin : g_clear
         assign reload = clr_wr & bus_wdata[FB];
      end

      dcs_sticky u_flag (
         .clk      (clk),
         .rst_n    (rst_n),
         .event_i  (sense_sync[i]),
         .reload_i (reload),
         .flag_o   (sticky_q[i])
      );
   end

   always_comb begin
      word = ctl_word;
      for (int unsigned i = 0; i < NUM_STICKY; i++) begin
         word[sticky_bit(i)] = sticky_q[i];
      end
   end

   assign bus_rdata   = (hit_set | hit_clr) ? word : '0;
   assign srst_assert = ctl_word[BIT_SRST];
   assign trst_assert = ctl_word[BIT_TRST];
   assign pwr_en      = ~ctl_word[BIT_PWR_OFF];
   assign led         = {ctl_word[BIT_LED1], ctl_word[BIT_LED0]};
   assign rclk_sel    = ctl_word[BIT_RCLK];

   // R3 R12
   ctl_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable({srst_assert, trst_assert, pwr_en, led, rclk_sel}));

endmodule

// File: tb/dbg_ctl_status_reg_tb.sv
`timescale 1ns/1ps
module dbg_ctl_status_reg_tb;

   localparam int SYNC = 2;
   localparam logic [31:0] MASK = 32'h0000_013B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h10;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        srst_in = 1'b0, drop_in = 1'b0, tmo_in = 1'b0;
   logic        srst_assert, trst_assert, pwr_en, rclk_sel;
   logic [1:0]  led;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dbg_ctl_status_reg #(.ADDR_W(8), .DATA_W(32), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .srst_sense_in(srst_in), .pwr_drop_in(drop_in), .clk_timeout_in(tmo_in),
      .srst_assert(srst_assert), .trst_assert(trst_assert), .pwr_en(pwr_en),
      .led(led), .rclk_sel(rclk_sel)
   );

   // Behavioural reference model
   logic [31:0] m_ctl;
   logic [2:0]  m_flag;
   logic [2:0]  m_s;
   logic [2:0]  pipe[$];
   logic        m_set, m_clr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctl  = '0;
         m_flag = '0;
         pipe.delete();
         for (int i = 0; i < SYNC; i++) pipe.push_back(3'b000);
      end else begin
         m_s   = pipe[0];
         m_set = bus_we && (bus_addr == 8'h10);
         m_clr = bus_we && (bus_addr == 8'h14);
         if (m_set)      m_ctl = m_ctl | (bus_wdata & MASK);
         else if (m_clr) m_ctl = m_ctl & ~(bus_wdata & MASK);
         if (m_set && bus_wdata[6]) m_flag[0] = m_s[0]; else m_flag[0] = m_flag[0] | m_s[0];
         if (m_set && bus_wdata[7]) m_flag[1] = m_s[1]; else m_flag[1] = m_flag[1] | m_s[1];
         if (m_clr && bus_wdata[10]) m_flag[2] = m_s[2]; else m_flag[2] = m_flag[2] | m_s[2];
         void'(pipe.pop_front());
         pipe.push_back({tmo_in, drop_in, srst_in});
      end
   end

   function automatic logic [31:0] model_rdata();
      logic [31:0] w;
      w = m_ctl | (32'(m_flag[0]) << 6) | (32'(m_flag[1]) << 7) | (32'(m_flag[2]) << 10);
      return ((bus_addr == 8'h10) || (bus_addr == 8'h14)) ? w : 32'h0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R3 srst_assert", 32'(srst_assert), 32'(m_ctl[0]));
      chk("R3 trst_assert", 32'(trst_assert), 32'(m_ctl[1]));
      chk("R4 pwr_en", 32'(pwr_en), 32'(!m_ctl[3]));
      chk("R5 led", 32'(led), 32'(m_ctl[5:4]));
      chk("R5 rclk_sel", 32'(rclk_sel), 32'(m_ctl[8]));
      chk("R6 bus_rdata", bus_rdata, model_rdata());
   endtask

   // Drive at the falling edge, let one rising edge pass, compare at the next falling edge
   task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d);
      bus_addr  = a;
      bus_we    = we;
      bus_wdata = d;
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 state during reset
      chk("R11 rdata", bus_rdata, 32'h0);
      chk("R11 pwr_en", 32'(pwr_en), 32'h1);
      chk("R11 srst", 32'(srst_assert), 32'h0);
      rst_n = 1'b1;
      step(8'h10, 1'b0, 32'h0);
      chk("R11 after release", bus_rdata, 32'h0);

      // R1 R3 R4 R5
      step(8'h10, 1'b1, 32'h0000_003B);
      step(8'h10, 1'b0, 32'h0);
      chk("R1 set word", bus_rdata, 32'h0000_003B);
      chk("R3 srst set", 32'(srst_assert), 32'h1);
      chk("R4 power off", 32'(pwr_en), 32'h0);
      chk("R5 leds", 32'(led), 32'h3);

      // R2 R6: read the clear address
      step(8'h14, 1'b1, 32'h0000_000A);
      step(8'h14, 1'b0, 32'h0);
      chk("R2 clear word", bus_rdata, 32'h0000_0031);
      chk("R2 trst cleared", 32'(trst_assert), 32'h0);
      chk("R4 power on", 32'(pwr_en), 32'h1);

      // R12: undefined bits ignored, R5 rclk
      step(8'h10, 1'b1, 32'hFFFF_FFFF);
      step(8'h10, 1'b0, 32'h0);
      chk("R12 undefined bits", bus_rdata, 32'h0000_013B);
      chk("R5 rclk_sel", 32'(rclk_sel), 32'h1);
      step(8'h14, 1'b1, 32'hFFFF_FFFF);
      step(8'h18, 1'b1, 32'hFFFF_FFFF);
      step(8'h18, 1'b0, 32'h0);
      chk("R6 unmapped reads zero", bus_rdata, 32'h0);
      step(8'h10, 1'b0, 32'h0);
      chk("R12 unmapped write", bus_rdata, 32'h0);

      // R7 latency and hold
      srst_in = 1'b1;
      step(8'h10, 1'b0, 32'h0);
      srst_in = 1'b0;
      step(8'h10, 1'b0, 32'h0);
      chk("R7 not yet", bus_rdata, 32'h0);
      step(8'h10, 1'b0, 32'h0);
      chk("R7 flag due", bus_rdata, 32'h0000_0040);
      step(8'h10, 1'b0, 32'h0);
      chk("R7 flag held", bus_rdata, 32'h0000_0040);

      // R8: clear port ignored, re-arm samples low input
      step(8'h14, 1'b1, 32'h0000_00C0);
      step(8'h10, 1'b0, 32'h0);
      chk("R8 clear ignored", bus_rdata, 32'h0000_0040);
      step(8'h10, 1'b1, 32'h0000_0040);
      step(8'h10, 1'b0, 32'h0);
      chk("R8 rearm low", bus_rdata, 32'h0);

      // R10: re-arm while dropout still present
      drop_in = 1'b1;
      step(8'h10, 1'b0, 32'h0);
      step(8'h10, 1'b0, 32'h0);
      step(8'h10, 1'b0, 32'h0);
      chk("R7 dropout flag", bus_rdata, 32'h0000_0080);
      step(8'h10, 1'b1, 32'h0000_0080);
      step(8'h10, 1'b0, 32'h0);
      chk("R10 rearm during event", bus_rdata, 32'h0000_0080);
      drop_in = 1'b0;
      step(8'h10, 1'b0, 32'h0);
      step(8'h10, 1'b0, 32'h0);
      step(8'h10, 1'b1, 32'h0000_0080);
      step(8'h10, 1'b0, 32'h0);
      chk("R8 rearm after drain", bus_rdata, 32'h0);

      // R9 timeout flag
      tmo_in = 1'b1;
      step(8'h10, 1'b0, 32'h0);
      tmo_in = 1'b0;
      step(8'h10, 1'b0, 32'h0);
      step(8'h10, 1'b0, 32'h0);
      chk("R9 timeout flag", bus_rdata, 32'h0000_0400);
      step(8'h10, 1'b1, 32'h0000_0400);
      step(8'h10, 1'b0, 32'h0);
      chk("R9 set port ignored", bus_rdata, 32'h0000_0400);
      step(8'h14, 1'b1, 32'h0000_0400);
      step(8'h10, 1'b0, 32'h0);
      chk("R9 cleared", bus_rdata, 32'h0);
      tmo_in = 1'b1;
      step(8'h10, 1'b0, 32'h0);
      step(8'h10, 1'b0, 32'h0);
      step(8'h10, 1'b0, 32'h0);
      step(8'h14, 1'b1, 32'h0000_0400);
      step(8'h14, 1'b0, 32'h0);
      chk("R10 clear during event", bus_rdata, 32'h0000_0400);
      tmo_in = 1'b0;

      // Mixed traffic against the model, R1 R2 R6 R7 R8 R9 R10 R12
      for (int n = 0; n < 600; n++) begin
         logic [7:0] a;
         case ($urandom % 5)
            0, 1:    a = 8'h10;
            2, 3:    a = 8'h14;
            default: a = 8'h18;
         endcase
         srst_in = (($urandom % 6) == 0);
         drop_in = (($urandom % 6) == 0);
         tmo_in  = (($urandom % 6) == 0);
         step(a, (($urandom % 2) == 0), $urandom);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule